// File: doc/BRIEF.md
# Segment translation and protection unit

This block turns a logical address given as a segment number plus an offset into a physical address. It looks the segment up in a small table of base/limit entries held in flops. Before it produces an address it applies four checks: the segment number must lie below a programmable table length, the entry must be marked live, the offset must lie inside the segment, and the entry's permission bits must allow the requested access. A request that fails any check returns a trap with a cause code in place of an address.

Requests and results each move over a valid/ready pair. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its result appears on the next edge and is registered. A result stays on the outputs, unchanged, until the cycle in which `res_ready` is high. While a result is waiting and `res_ready` is low, `req_ready` is low. When `res_ready` is high, a new request can be taken in the same cycle in which the old result leaves.

Software-side loading is done through two plain control ports. One writes a table entry and the other writes the table length. Neither port has a handshake, and both take effect from the cycle after the write.

Top module: `seg_xlate_unit`

## Requirements
- R1: A request taken on an edge (`req_valid` and `req_ready` high) makes `res_valid` high after that edge, with the result for that request.
- R2: While `res_valid` is high and `res_ready` is low, `req_ready` is low and every result output holds its value. `req_ready` is high whenever `res_valid` is low or `res_ready` is high.
- R3: If the segment number is greater than or equal to the table length, the result is a trap with cause 1.
- R4: If the segment is in range but its entry's live bit is 0, the result is a trap with cause 2.
- R5: If the offset is greater than or equal to the entry's limit, the result is a trap with cause 3. A limit of 0 therefore traps every offset.
- R6: The access code selects a permission bit: 0 is read and needs perm bit 0, 1 is write and needs perm bit 1, 2 is execute and needs perm bit 2. Code 3 is always refused. A refused access traps with cause 4.
- R7: When all checks pass, `res_ok` is 1, `res_trap` is 0, cause is 0 and `res_paddr` equals base plus offset modulo 2^BASE_W. When a request traps, `res_ok` is 0, `res_trap` is 1 and `res_paddr` is 0.
- R8: When several checks fail at once, the cause reported is the first failing check in this order: range (1), live (2), limit (3), permission (4).
- R9: A table write is not seen by a request taken on the same edge. Requests taken from the next edge on use the new entry.
- R10: After reset, `res_valid` is 0, the table length is 0 and every entry is not live.
- R11: A length write is not seen by a request taken on the same edge. Later requests use the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_wr | input | 1 | Load the table length register |
| len_data | input | IDX_W+1 | New table length |
| tbl_wr | input | 1 | Write one table entry |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_base | input | BASE_W | Entry base (physical start) |
| tbl_limit | input | OFF_W | Entry length |
| tbl_live | input | 1 | Entry live bit |
| tbl_perm | input | 3 | Permission bits: 0 read, 1 write, 2 execute |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_seg | input | IDX_W | Segment number |
| req_off | input | OFF_W | Offset within segment |
| req_acc | input | 2 | Access code (0 read, 1 write, 2 execute, 3 reserved) |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_ok | output | 1 | Translation succeeded |
| res_trap | output | 1 | Request trapped |
| res_cause | output | 3 | Trap cause (0 none, 1..4 as in requirements) |
| res_paddr | output | BASE_W | Physical address |

## Verification
The bench builds the block with its defaults: 8 segments, a 16-bit offset and limit, and a 24-bit base. With only eight entries, random traffic reaches every index and every length from 0 to 8 many times. A 16-bit offset allows directed requests at limit-1, at limit, at a limit of zero and at 0xFFFF. A 24-bit base placed near its top value exercises the wrap of the address sum. The bench also has directed cases for the following:
- a request and a write to the same entry on the same edge;
- a length write on the same edge as a request;
- several checks failing at once;
- a stalled consumer.

// File: rtl/segx_pkg.sv
package segx_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    CZ_NONE    = 3'd0,
    CZ_RANGE   = 3'd1,
    CZ_DEAD    = 3'd2,
    CZ_LIMIT   = 3'd3,
    CZ_PERM    = 3'd4
  } cause_e;

  localparam int PERM_W = 3;
endpackage

// File: rtl/segx_table.sv
module segx_table
  import segx_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int OFF_W   = 16,
  parameter int BASE_W  = 24,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [OFF_W-1:0]  wr_limit,
  input  logic              wr_live,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [OFF_W-1:0]  rd_limit,
  output logic              rd_live,
  output logic [PERM_W-1:0] rd_perm
);
  logic [BASE_W-1:0] base_q  [NUM_SEG];
  logic [OFF_W-1:0]  limit_q [NUM_SEG];
  logic              live_q  [NUM_SEG];
  logic [PERM_W-1:0] perm_q  [NUM_SEG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SEG; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        live_q[i]  <= 1'b0;
        perm_q[i]  <= '0;
      end
    end else if (wr_en && (int'(wr_idx) < NUM_SEG)) begin
      base_q[wr_idx]  <= wr_base;
      limit_q[wr_idx] <= wr_limit;
      live_q[wr_idx]  <= wr_live;
      perm_q[wr_idx]  <= wr_perm;
    end
  end

  always_comb begin
    rd_base  = '0;
    rd_limit = '0;
    rd_live  = 1'b0;
    rd_perm  = '0;
    if (int'(rd_idx) < NUM_SEG) begin
      rd_base  = base_q[rd_idx];
      rd_limit = limit_q[rd_idx];
      rd_live  = live_q[rd_idx];
      rd_perm  = perm_q[rd_idx];
    end
  end
endmodule

// File: rtl/segx_check.sv
module segx_check
  import segx_pkg::*;
#(
  parameter int OFF_W  = 16,
  parameter int BASE_W = 24,
  parameter int IDX_W  = 3,
  parameter int LEN_W  = IDX_W + 1
) (
  input  logic [IDX_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        acc,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic [BASE_W-1:0] ent_base,
  input  logic [OFF_W-1:0]  ent_limit,
  input  logic              ent_live,
  input  logic [PERM_W-1:0] ent_perm,
  output logic [2:0]        cause,
  output logic [BASE_W-1:0] paddr
);
  logic in_range, in_limit, perm_ok;

  assign in_range = {1'b0, seg} < seg_len;
  assign in_limit = off < ent_limit;

  always_comb begin
    unique case (acc_e'(acc))
      ACC_READ:  perm_ok = ent_perm[0];
      ACC_WRITE: perm_ok = ent_perm[1];
      ACC_EXEC:  perm_ok = ent_perm[2];
      default:   perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (!in_range)      cause = CZ_RANGE;
    else if (!ent_live) cause = CZ_DEAD;
    else if (!in_limit) cause = CZ_LIMIT;
    else if (!perm_ok)  cause = CZ_PERM;
    else                cause = CZ_NONE;
  end

  assign paddr = (cause == CZ_NONE) ? ent_base + BASE_W'(off) : '0;
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import segx_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int OFF_W   = 16,
  parameter int BASE_W  = 24,
  localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int LEN_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_data,
  input  logic              tbl_wr,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [BASE_W-1:0] tbl_base,
  input  logic [OFF_W-1:0]  tbl_limit,
  input  logic              tbl_live,
  input  logic [2:0]        tbl_perm,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_acc,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_ok,
  output logic              res_trap,
  output logic [2:0]        res_cause,
  output logic [BASE_W-1:0] res_paddr
);
  logic [LEN_W-1:0]  len_q;
  logic [BASE_W-1:0] e_base;
  logic [OFF_W-1:0]  e_limit;
  logic              e_live;
  logic [PERM_W-1:0] e_perm;
  logic [2:0]        c_cause;
  logic [BASE_W-1:0] c_paddr;
  logic              fire;

  always_ff @(posedge clk) begin
    if (!rst_n)      len_q <= '0;
    else if (len_wr) len_q <= len_data;
  end

  segx_table #(
    .NUM_SEG(NUM_SEG), .OFF_W(OFF_W), .BASE_W(BASE_W), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr), .wr_idx(tbl_idx), .wr_base(tbl_base),
    .wr_limit(tbl_limit), .wr_live(tbl_live), .wr_perm(tbl_perm),
    .rd_idx(req_seg), .rd_base(e_base), .rd_limit(e_limit),
    .rd_live(e_live), .rd_perm(e_perm)
  );

  segx_check #(
    .OFF_W(OFF_W), .BASE_W(BASE_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_check (
    .seg(req_seg), .off(req_off), .acc(req_acc), .seg_len(len_q),
    .ent_base(e_base), .ent_limit(e_limit), .ent_live(e_live),
    .ent_perm(e_perm), .cause(c_cause), .paddr(c_paddr)
  );

  assign req_ready = !res_valid || res_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
      res_trap  <= 1'b0;
      res_cause <= '0;
      res_paddr <= '0;
    end else if (fire) begin
      res_valid <= 1'b1;
      res_ok    <= (c_cause == CZ_NONE);
      res_trap  <= (c_cause != CZ_NONE);
      res_cause <= c_cause;
      res_paddr <= c_paddr;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int BASE_W = 24,
  parameter int IDX_W  = 3,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [IDX_W-1:0]  req_seg,
  input logic [LEN_W-1:0]  len_q,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_ok,
  input logic              res_trap,
  input logic [2:0]        res_cause,
  input logic [BASE_W-1:0] res_paddr
);
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid); // R1
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !req_ready); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_cause) && $stable(res_paddr) && $stable(res_ok))); // R2
  AST_RANGE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ({1'b0, req_seg} >= len_q)) |=> (res_trap && res_cause == 3'd1)); // R3
  AST_OK_XOR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_ok != res_trap)); // R7
  AST_OK_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ok) |-> (res_cause == 3'd0)); // R7
  AST_TRAP_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_trap) |-> (res_paddr == '0 && res_cause != 3'd0 && res_cause <= 3'd4)); // R7
endmodule

bind seg_xlate_unit seg_xlate_chk #(
  .BASE_W(BASE_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_seg(req_seg), .len_q(len_q), .res_valid(res_valid),
  .res_ready(res_ready), .res_ok(res_ok), .res_trap(res_trap),
  .res_cause(res_cause), .res_paddr(res_paddr)
);

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;
  localparam int CLK_P  = 10;
  localparam int NSEG   = 8;
  localparam int OW     = 16;
  localparam int BW     = 24;
  localparam int IW     = 3;
  localparam int LW     = 4;

  logic clk = 0, rst_n = 0;
  logic len_wr = 0; logic [LW-1:0] len_data = '0;
  logic tbl_wr = 0; logic [IW-1:0] tbl_idx = '0; logic [BW-1:0] tbl_base = '0;
  logic [OW-1:0] tbl_limit = '0; logic tbl_live = 0; logic [2:0] tbl_perm = '0;
  logic req_valid = 0, req_ready; logic [IW-1:0] req_seg = '0;
  logic [OW-1:0] req_off = '0; logic [1:0] req_acc = '0;
  logic res_valid, res_ready = 1, res_ok, res_trap;
  logic [2:0] res_cause; logic [BW-1:0] res_paddr;

  int checks = 0, bad = 0; bit done = 0;

  logic [BW-1:0] m_base [NSEG];
  logic [OW-1:0] m_lim  [NSEG];
  logic          m_live [NSEG];
  logic [2:0]    m_perm [NSEG];
  logic [LW-1:0] m_len;

  always #(CLK_P/2) clk = ~clk;

  seg_xlate_unit dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] model(input logic [IW-1:0] s, input logic [OW-1:0] o, input logic [1:0] a);
    logic [2:0] c; logic pok;
    case (a)
      2'd0: pok = m_perm[s][0];
      2'd1: pok = m_perm[s][1];
      2'd2: pok = m_perm[s][2];
      default: pok = 1'b0;
    endcase
    if ({1'b0, s} >= m_len) c = 3'd1;
    else if (!m_live[s])    c = 3'd2;
    else if (o >= m_lim[s]) c = 3'd3;
    else if (!pok)          c = 3'd4;
    else                    c = 3'd0;
    return {c, (c == 3'd0) ? m_base[s] + BW'(o) : BW'(0)};
  endfunction

  task automatic check_res(input logic [26:0] e, input string tag);
    chk(res_valid == 1'b1, {tag, " valid"}, 32'(res_valid), 1);
    chk({res_cause, res_paddr} == e, {tag, " cause/paddr"}, 32'({res_cause, res_paddr}), 32'(e));
    chk(res_ok == (e[26:24] == 3'd0) && res_trap == (e[26:24] != 3'd0), {tag, " ok/trap"},
        32'({res_ok, res_trap}), 32'({e[26:24] == 3'd0, e[26:24] != 3'd0}));
  endtask

  task automatic put_entry(input int i, input logic [BW-1:0] b, input logic [OW-1:0] l, input logic v, input logic [2:0] p);
    @(negedge clk);
    tbl_wr = 1; tbl_idx = IW'(i); tbl_base = b; tbl_limit = l; tbl_live = v; tbl_perm = p;
    @(negedge clk);
    tbl_wr = 0;
    m_base[i] = b; m_lim[i] = l; m_live[i] = v; m_perm[i] = p;
  endtask

  task automatic put_len(input logic [LW-1:0] n);
    @(negedge clk); len_wr = 1; len_data = n;
    @(negedge clk); len_wr = 0; m_len = n;
  endtask

  task automatic do_req(input int s, input logic [OW-1:0] o, input logic [1:0] a, input string tag);
    logic [26:0] e;
    @(negedge clk);
    req_valid = 1; req_seg = IW'(s); req_off = o; req_acc = a;
    e = model(IW'(s), o, a);
    @(negedge clk);
    req_valid = 0;
    check_res(e, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [26:0] e;
    for (int i = 0; i < NSEG; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_live[i] = 0; m_perm[i] = '0;
    end
    m_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(res_valid == 0, "R10 res_valid after reset", 32'(res_valid), 0);
    chk(req_ready == 1, "R10 req_ready after reset", 32'(req_ready), 1);
    do_req(0, 16'h0, 2'd0, "R10 length zero after reset");
    put_len(4'd8);
    do_req(5, 16'h0, 2'd0, "R10 entries dead after reset");

    put_entry(1, 24'h001000, 16'h0100, 1, 3'b001);
    do_req(1, 16'h00FF, 2'd0, "R7 read at limit-1");
    do_req(1, 16'h0100, 2'd0, "R5 offset at limit");
    do_req(1, 16'h0010, 2'd1, "R6 write without W bit");
    do_req(1, 16'h0010, 2'd2, "R6 exec without X bit");
    put_entry(2, 24'h200000, 16'hFFFF, 1, 3'b111);
    do_req(2, 16'hFFFE, 2'd3, "R6 reserved code refused");
    do_req(2, 16'hFFFE, 2'd2, "R6 exec allowed");
    do_req(2, 16'hFFFF, 2'd1, "R5 max offset at max limit");
    put_entry(3, 24'hFFFFF0, 16'h0100, 1, 3'b010);
    do_req(3, 16'h0020, 2'd1, "R7 address wraps");
    put_entry(4, 24'h000500, 16'h0000, 1, 3'b111);
    do_req(4, 16'h0000, 2'd0, "R5 zero limit");

    put_entry(6, 24'h0, 16'h0, 0, 3'b000);
    do_req(6, 16'h0005, 2'd3, "R8 dead beats limit and perm");
    put_entry(6, 24'h0, 16'h0004, 1, 3'b000);
    do_req(6, 16'h0005, 2'd3, "R8 limit beats perm");
    put_len(4'd6);
    do_req(6, 16'h0005, 2'd3, "R8 range beats all");
    do_req(7, 16'h0000, 2'd0, "R3 segment above length");
    put_len(4'd8);

    // R9: write and request on the same edge
    @(negedge clk);
    req_valid = 1; req_seg = 3'd1; req_off = 16'h0010; req_acc = 2'd1;
    tbl_wr = 1; tbl_idx = 3'd1; tbl_base = 24'h0A0000; tbl_limit = 16'h0100; tbl_live = 1; tbl_perm = 3'b011;
    e = model(3'd1, 16'h0010, 2'd1);
    @(negedge clk);
    req_valid = 0; tbl_wr = 0;
    m_base[1] = 24'h0A0000; m_perm[1] = 3'b011;
    check_res(e, "R9 same-edge write unseen");
    do_req(1, 16'h0010, 2'd1, "R9 write seen next");

    // R11: length write on the same edge
    @(negedge clk);
    req_valid = 1; req_seg = 3'd2; req_off = 16'h0001; req_acc = 2'd0;
    len_wr = 1; len_data = 4'd2;
    e = model(3'd2, 16'h0001, 2'd0);
    @(negedge clk);
    req_valid = 0; len_wr = 0; m_len = 4'd2;
    check_res(e, "R11 same-edge length unseen");
    do_req(2, 16'h0001, 2'd0, "R11 length seen next");
    put_len(4'd8);

    // R2: stalled consumer
    @(negedge clk);
    res_ready = 0;
    req_valid = 1; req_seg = 3'd2; req_off = 16'h0040; req_acc = 2'd0;
    e = model(3'd2, 16'h0040, 2'd0);
    @(negedge clk);
    req_seg = 3'd3; req_off = 16'h0008; req_acc = 2'd1;
    chk(req_ready == 0, "R2 ready low in stall", 32'(req_ready), 0);
    check_res(e, "R1 first result");
    repeat (2) @(negedge clk);
    chk(req_ready == 0, "R2 ready still low", 32'(req_ready), 0);
    check_res(e, "R2 result held");
    res_ready = 1;
    e = model(3'd3, 16'h0008, 2'd1);
    @(negedge clk);
    req_valid = 0;
    check_res(e, "R2 next result after release");
    @(negedge clk);
    chk(res_valid == 0, "R1 drains", 32'(res_valid), 0);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int r; int s; logic [OW-1:0] o; logic [1:0] a; string tag;
      r = int'($urandom_range(0, 99));
      if (r < 25) put_entry(int'($urandom_range(0, NSEG-1)), BW'($urandom), OW'($urandom_range(0, 600)),
                            1'($urandom_range(0, 4) != 0), 3'($urandom));
      else if (r < 30) put_len(LW'($urandom_range(0, 8)));
      s = int'($urandom_range(0, NSEG-1));
      case ($urandom_range(0, 2))
        0: o = m_lim[s] - 16'd1;
        1: o = m_lim[s];
        default: o = OW'($urandom_range(0, 700));
      endcase
      a = 2'($urandom);
      e = model(IW'(s), o, a);
      case (e[26:24])
        3'd0: tag = "R7 random pass";
        3'd1: tag = "R3 random range";
        3'd2: tag = "R4 random dead";
        3'd3: tag = "R5 random limit";
        default: tag = "R6 random perm";
      endcase
      do_req(s, o, a, tag);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule